// File: doc/BRIEF.md
# Fully Associative Micro TLB

This block is a small translation cache placed next to one memory access port. Each cycle it takes a 32-bit virtual address together with the current 8-bit address-space identifier. Without any register stage it reports a hit or a miss. On a hit it also returns the physical address, the attribute bits of the entry and a fault verdict from the domain and permission checks. On a miss it raises a refill request. A larger backing TLB then supplies the missing translation through a one-cycle refill strobe.

Any translation can be placed in any entry. Each entry stores its own page size, so each entry compares only the virtual address bits above its own page offset. An entry can be marked global so that it ignores the address-space identifier. Refills always go to the slot named by a round-robin pointer. Three maintenance operations are available: clear all entries, clear by identifier, and clear by address.

Top module: `micro_tlb`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses and the round-robin pointer stands at slot 0.
- R2: Page size codes are 00 for 4 KB, 01 for 64 KB, 10 for 1 MB and 11 for 16 MB, giving offsets of 12, 16, 20 and 24 bits. An entry compares only the address bits above its offset. On a hit, physAddr takes the stored frame bits above the offset and the lookup address bits below it.
- R3: An entry with the global flag set matches under any identifier. An entry without it matches only when its stored identifier equals curAsid.
- R4: When more than one entry matches, the result comes from the entry with the lowest index.
- R5: A refill writes the slot at the round-robin pointer and then advances the pointer by one. After the last slot the pointer wraps to 0, so the 33rd refill after reset overwrites slot 0.
- R6: The domain number d of the hit entry selects domainCtrl[2d+1:2d]. The value 00 or 10 raises domainFault. The value 11 (manager) raises no fault of either kind. The value 01 (client) applies the permission check.
- R7: Under a client domain, permission bit 1 allows unprivileged access and permission bit 0 allows writes. permFault is raised when privMode is 0 and bit 1 is clear, or when writeAccess is 1 and bit 0 is clear. Neither fault is raised without a hit.
- R8: On a hit, attrOut equals the attribute bits stored with the winning entry.
- R9: invAll makes every entry invalid from the next cycle on.
- R10: invAsid clears only non-global entries whose identifier equals invAsidVal. Global entries and entries with other identifiers stay valid.
- R11: invVa clears every entry whose size-masked page number covers invVpn, whatever its identifier or global flag.
- R12: When a refill and an invalidate happen in the same cycle, the invalidate is applied to the other entries and the refilled slot holds the new, valid entry.
- R13: hit and missReq are never high together. Both are low when lookupValid is low, and missReq equals lookupValid with no match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lookupValid | input | 1 | A lookup is presented this cycle |
| lookupVa | input | 32 | Virtual address to translate |
| curAsid | input | 8 | Current address-space identifier |
| privMode | input | 1 | Access is privileged |
| writeAccess | input | 1 | Access is a write |
| domainCtrl | input | 32 | Sixteen 2-bit domain access fields |
| hit | output | 1 | Lookup matched an entry |
| missReq | output | 1 | Lookup missed; refill wanted |
| physAddr | output | 32 | Translated address |
| attrOut | output | 5 | Memory attributes of the hit entry |
| domainFault | output | 1 | Domain denies the access |
| permFault | output | 1 | Client permission check failed |
| refillValid | input | 1 | Write a new entry this cycle |
| refillVpn | input | 20 | Virtual page number of new entry |
| refillPpn | input | 20 | Physical frame number of new entry |
| refillSize | input | 2 | Page size code of new entry |
| refillAsid | input | 8 | Identifier of new entry |
| refillGlobal | input | 1 | New entry is global |
| refillDomain | input | 4 | Domain number of new entry |
| refillPerm | input | 2 | Permission bits of new entry |
| refillAttr | input | 5 | Attribute bits of new entry |
| invAll | input | 1 | Invalidate every entry |
| invAsid | input | 1 | Invalidate by identifier |
| invAsidVal | input | 8 | Identifier for invAsid |
| invVa | input | 1 | Invalidate by address |
| invVpn | input | 20 | Page number for invVa |

## Verification
The bench builds the block with its default of 32 entries. With that value, 33 back-to-back refills are enough to show the pointer wrapping onto slot 0. Refill and lookup addresses are drawn from a narrow region with a few identifiers. Pages of different sizes therefore overlap often, which exercises lowest-index priority, global matching and the per-entry masks in invalidate-by-address. Random domain words reach all four domain field codes under every combination of privilege and write.

// File: rtl/utlb_pkg.sv
package utlb_pkg;
  localparam int VA_W   = 32;
  localparam int OFF_W  = 12;
  localparam int PN_W   = VA_W - OFF_W;
  localparam int ASID_W = 8;
  localparam int DOM_W  = 4;
  localparam int ATTR_W = 5;
  localparam int PERM_W = 2;

  typedef enum logic [1:0] {
    PG_4K  = 2'b00,
    PG_64K = 2'b01,
    PG_1M  = 2'b10,
    PG_16M = 2'b11
  } pageSize_e;

  typedef struct packed {
    logic              valid;
    logic              glob;
    logic [ASID_W-1:0] asid;
    logic [PN_W-1:0]   vpn;
    logic [PN_W-1:0]   ppn;
    pageSize_e         size;
    logic [DOM_W-1:0]  dom;
    logic [PERM_W-1:0] perm;
    logic [ATTR_W-1:0] attr;
  } tlbEntry_t;

  typedef struct packed {
    logic refillWe;
    logic clrAll;
    logic clrAsid;
    logic clrVa;
  } ctrlStrobe_t;

  // page-number bits that take part in a compare for a given size
  function automatic logic [PN_W-1:0] pageMask(pageSize_e s);
    logic [PN_W-1:0] m;
    case (s)
      PG_4K:   m = {PN_W{1'b1}};
      PG_64K:  m = {PN_W{1'b1}} << 4;
      PG_1M:   m = {PN_W{1'b1}} << 8;
      default: m = {PN_W{1'b1}} << 12;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/utlb_datapath.sv
module utlb_datapath
  import utlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 32,
  parameter int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [IDX_W-1:0]  slot,
  input  tlbEntry_t         newEntry,
  input  logic [VA_W-1:0]   lookupVa,
  input  logic [ASID_W-1:0] curAsid,
  input  logic [ASID_W-1:0] invAsidVal,
  input  logic [PN_W-1:0]   invVpn,
  output logic              anyHit,
  output tlbEntry_t         hitEntry,
  output logic [VA_W-1:0]   physAddr
);
  tlbEntry_t entries [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] matchVec;
  logic [NUM_ENTRIES-1:0] clrVec;
  logic [PN_W-1:0] lookVpn;
  logic [IDX_W-1:0] selIdx;

  assign lookVpn = lookupVa[VA_W-1:OFF_W];

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_entry
    logic [PN_W-1:0] mask;
    logic tagEq, asidOk, invCover, asidKill;
    assign mask     = pageMask(entries[i].size);
    assign tagEq    = ((lookVpn ^ entries[i].vpn) & mask) == '0;
    assign asidOk   = entries[i].glob || (entries[i].asid == curAsid);
    assign matchVec[i] = entries[i].valid && tagEq && asidOk;
    assign invCover = ((invVpn ^ entries[i].vpn) & mask) == '0;
    assign asidKill = !entries[i].glob && (entries[i].asid == invAsidVal);
    assign clrVec[i] = strobe.clrAll || (strobe.clrAsid && asidKill)
                     || (strobe.clrVa && invCover);
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (!rstN) begin
        entries[i] <= '0;
      end else if (strobe.refillWe && slot == IDX_W'(i)) begin
        entries[i] <= newEntry;
      end else if (clrVec[i]) begin
        entries[i].valid <= 1'b0;
      end
    end
  end

  // lowest index wins
  always_comb begin
    selIdx = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (matchVec[i]) selIdx = IDX_W'(i);
    end
  end

  assign anyHit   = |matchVec;
  assign hitEntry = entries[selIdx];

  logic [PN_W-1:0] hitMask;
  assign hitMask  = pageMask(hitEntry.size);
  assign physAddr = {(hitEntry.ppn & hitMask) | (lookVpn & ~hitMask),
                     lookupVa[OFF_W-1:0]};
endmodule

// File: rtl/utlb_perm.sv
module utlb_perm
  import utlb_pkg::*;
(
  input  logic              hitQual,
  input  logic [DOM_W-1:0]  dom,
  input  logic [PERM_W-1:0] perm,
  input  logic [2*(1<<DOM_W)-1:0] domainCtrl,
  input  logic              privMode,
  input  logic              writeAccess,
  output logic              domainFault,
  output logic              permFault
);
  logic [1:0] field;
  assign field = domainCtrl[2*dom +: 2];

  always_comb begin
    domainFault = 1'b0;
    permFault   = 1'b0;
    case (field)
      2'b11: ;
      2'b01: permFault = hitQual && ((!privMode && !perm[1]) ||
                                     (writeAccess && !perm[0]));
      default: domainFault = hitQual;
    endcase
  end
endmodule

// File: rtl/utlb_ctrl.sv
module utlb_ctrl
  import utlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 32,
  parameter int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             refillValid,
  input  logic             invAll,
  input  logic             invAsid,
  input  logic             invVa,
  output ctrlStrobe_t      strobe,
  output logic [IDX_W-1:0] rrPtr
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_ENTRIES - 1);

  assign strobe.refillWe = refillValid;
  assign strobe.clrAll   = invAll;
  assign strobe.clrAsid  = invAsid;
  assign strobe.clrVa    = invVa;

  always_ff @(posedge clk) begin
    if (!rstN) rrPtr <= '0;
    else if (refillValid) rrPtr <= (rrPtr == LAST) ? '0 : rrPtr + 1'b1;
  end
endmodule

// File: rtl/micro_tlb.sv
module micro_tlb
  import utlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lookupValid,
  input  logic [31:0]       lookupVa,
  input  logic [7:0]        curAsid,
  input  logic              privMode,
  input  logic              writeAccess,
  input  logic [31:0]       domainCtrl,
  output logic              hit,
  output logic              missReq,
  output logic [31:0]       physAddr,
  output logic [4:0]        attrOut,
  output logic              domainFault,
  output logic              permFault,
  input  logic              refillValid,
  input  logic [19:0]       refillVpn,
  input  logic [19:0]       refillPpn,
  input  logic [1:0]        refillSize,
  input  logic [7:0]        refillAsid,
  input  logic              refillGlobal,
  input  logic [3:0]        refillDomain,
  input  logic [1:0]        refillPerm,
  input  logic [4:0]        refillAttr,
  input  logic              invAll,
  input  logic              invAsid,
  input  logic [7:0]        invAsidVal,
  input  logic              invVa,
  input  logic [19:0]       invVpn
);
  localparam int IDX_W = $clog2(NUM_ENTRIES);

  ctrlStrobe_t      strobe;
  logic [IDX_W-1:0] rrPtr;
  tlbEntry_t        newEntry, hitEntry;
  logic             anyHit;

  assign newEntry = '{valid: 1'b1, glob: refillGlobal, asid: refillAsid,
                      vpn: refillVpn, ppn: refillPpn,
                      size: pageSize_e'(refillSize), dom: refillDomain,
                      perm: refillPerm, attr: refillAttr};

  utlb_ctrl #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .refillValid(refillValid), .invAll(invAll),
    .invAsid(invAsid), .invVa(invVa), .strobe(strobe), .rrPtr(rrPtr)
  );

  utlb_datapath #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .slot(rrPtr),
    .newEntry(newEntry), .lookupVa(lookupVa), .curAsid(curAsid),
    .invAsidVal(invAsidVal), .invVpn(invVpn), .anyHit(anyHit),
    .hitEntry(hitEntry), .physAddr(physAddr)
  );

  assign hit     = lookupValid && anyHit;
  assign missReq = lookupValid && !anyHit;
  assign attrOut = hitEntry.attr;

  utlb_perm i_perm (
    .hitQual(hit), .dom(hitEntry.dom), .perm(hitEntry.perm),
    .domainCtrl(domainCtrl), .privMode(privMode),
    .writeAccess(writeAccess), .domainFault(domainFault),
    .permFault(permFault)
  );
endmodule

// File: rtl/utlb_checker.sv
module utlb_checker (
  input logic        clk,
  input logic        rstN,
  input logic        lookupValid,
  input logic [31:0] lookupVa,
  input logic [31:0] domainCtrl,
  input logic        hit,
  input logic        missReq,
  input logic [31:0] physAddr,
  input logic        domainFault,
  input logic        permFault,
  input logic        invAll,
  input logic        refillValid
);
  // R13
  hit_miss_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> !missReq);
  // R13
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lookupValid |-> (!hit && !missReq));
  // R2
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> physAddr[11:0] == lookupVa[11:0]);
  // R7
  fault_needs_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (domainFault || permFault) |-> hit);
  // R6
  manager_clean_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hit && domainCtrl == 32'hFFFF_FFFF) |-> (!domainFault && !permFault));
  // R6
  no_access_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hit && domainCtrl == 32'h0) |-> domainFault);
  // R9
  inv_all_chk: assert property (@(posedge clk) disable iff (!rstN)
    (invAll && !refillValid) |=> !hit);
endmodule

bind micro_tlb utlb_checker i_chk (
  .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .lookupVa(lookupVa),
  .domainCtrl(domainCtrl), .hit(hit), .missReq(missReq),
  .physAddr(physAddr), .domainFault(domainFault), .permFault(permFault),
  .invAll(invAll), .refillValid(refillValid)
);

// File: tb/test_micro_tlb.sv
module test_micro_tlb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 32;

  logic clk = 0, rstN = 0;
  logic lookupValid = 0, privMode = 0, writeAccess = 0;
  logic [31:0] lookupVa = 0, domainCtrl = 0, physAddr;
  logic [7:0] curAsid = 0, refillAsid = 0, invAsidVal = 0;
  logic hit, missReq, domainFault, permFault;
  logic [4:0] attrOut, refillAttr = 0;
  logic refillValid = 0, refillGlobal = 0, invAll = 0, invAsid = 0, invVa = 0;
  logic [19:0] refillVpn = 0, refillPpn = 0, invVpn = 0;
  logic [1:0] refillSize = 0, refillPerm = 0;
  logic [3:0] refillDomain = 0;

  int total = 0, bad = 0;
  bit done = 0;

  // bench model of the entry array
  bit mValid [N];
  bit mGlob [N];
  logic [7:0] mAsid [N];
  logic [19:0] mVpn [N], mPpn [N];
  logic [1:0] mSize [N], mPerm [N];
  logic [3:0] mDom [N];
  logic [4:0] mAttr [N];
  int mPtr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  micro_tlb #(.NUM_ENTRIES(N)) i_micro_tlb (.*);

  function automatic logic [19:0] maskOf(logic [1:0] s);
    case (s)
      2'b00: return 20'hFFFFF;
      2'b01: return 20'hFFFF0;
      2'b10: return 20'hFFF00;
      default: return 20'hFF000;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clearIns();
    refillValid = 0; invAll = 0; invAsid = 0; invVa = 0; lookupValid = 0;
  endtask

  task automatic doRefill(logic [19:0] vpn, logic [19:0] ppn, logic [1:0] sz,
                          logic [7:0] asid, bit glob, logic [3:0] dom,
                          logic [1:0] perm, logic [4:0] attr, bit withInvAll);
    @(negedge clk); clearIns();
    refillValid = 1; refillVpn = vpn; refillPpn = ppn; refillSize = sz;
    refillAsid = asid; refillGlobal = glob; refillDomain = dom;
    refillPerm = perm; refillAttr = attr; invAll = withInvAll;
    @(posedge clk); #1; clearIns();
    if (withInvAll) for (int i = 0; i < N; i++) mValid[i] = 0;
    mValid[mPtr] = 1; mGlob[mPtr] = glob; mAsid[mPtr] = asid;
    mVpn[mPtr] = vpn; mPpn[mPtr] = ppn; mSize[mPtr] = sz;
    mDom[mPtr] = dom; mPerm[mPtr] = perm; mAttr[mPtr] = attr;
    mPtr = (mPtr + 1) % N;
  endtask

  task automatic doInv(int kind, logic [7:0] asid, logic [19:0] vpn);
    @(negedge clk); clearIns();
    invAll = (kind == 0); invAsid = (kind == 1); invVa = (kind == 2);
    invAsidVal = asid; invVpn = vpn;
    @(posedge clk); #1; clearIns();
    for (int i = 0; i < N; i++) begin
      if (kind == 0) mValid[i] = 0;
      if (kind == 1 && !mGlob[i] && mAsid[i] == asid) mValid[i] = 0;
      if (kind == 2 && ((vpn ^ mVpn[i]) & maskOf(mSize[i])) == 0) mValid[i] = 0;
    end
  endtask

  // drive a lookup and compare every output against the model
  task automatic doLookup(string tag, logic [31:0] va, logic [7:0] asid,
                          bit priv, bit wr, logic [31:0] dc);
    bit eHit = 0, eDomF = 0, ePermF = 0;
    int w = 0;
    logic [31:0] ePa;
    logic [1:0] fld;
    @(negedge clk); clearIns();
    lookupValid = 1; lookupVa = va; curAsid = asid; privMode = priv;
    writeAccess = wr; domainCtrl = dc;
    #1;
    for (int i = N - 1; i >= 0; i--)
      if (mValid[i] && (mGlob[i] || mAsid[i] == asid) &&
          ((va[31:12] ^ mVpn[i]) & maskOf(mSize[i])) == 0) begin
        eHit = 1; w = i;
      end
    chk({tag, " hit"}, 32'(hit), 32'(eHit));
    chk({tag, " R13 miss"}, 32'(missReq), 32'(!eHit));
    if (eHit) begin
      ePa = {(mPpn[w] & maskOf(mSize[w])) | (va[31:12] & ~maskOf(mSize[w])),
             va[11:0]};
      fld = dc[2*mDom[w] +: 2];
      eDomF = (fld == 2'b00 || fld == 2'b10);
      ePermF = (fld == 2'b01) && ((!priv && !mPerm[w][1]) || (wr && !mPerm[w][0]));
      chk({tag, " R2 pa"}, physAddr, ePa);
      chk({tag, " R8 attr"}, 32'(attrOut), 32'(mAttr[w]));
    end
    chk({tag, " R6 domFault"}, 32'(domainFault), 32'(eDomF));
    chk({tag, " R7 permFault"}, 32'(permFault), 32'(ePermF));
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < N; i++) mValid[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;

    // R1: empty after reset
    doLookup("R1", 32'h0012_3456, 8'd1, 1, 0, 32'hFFFF_FFFF);
    chk("R1 missReq", 32'(missReq), 32'd1);

    // R4: overlapping 1MB (slot 0) and 4KB (slot 1); slot 0 wins
    doRefill(20'h00100, 20'h80000, 2'b10, 8'd1, 0, 4'd0, 2'b11, 5'h0A, 0);
    doRefill(20'h00123, 20'h90000, 2'b00, 8'd1, 0, 4'd0, 2'b11, 5'h15, 0);
    doLookup("R4", 32'h0012_3456, 8'd1, 1, 0, 32'hFFFF_FFFF);
    chk("R4 pa", physAddr, 32'h8002_3456);

    // R3: non-global entry misses under another identifier; global hits
    doLookup("R3", 32'h0012_3456, 8'd2, 1, 0, 32'hFFFF_FFFF);
    chk("R3 other asid", 32'(hit), 32'd0);
    doRefill(20'h40000, 20'h12340, 2'b01, 8'd9, 1, 4'd2, 2'b10, 5'h03, 0);
    doLookup("R3", 32'h4000_ABCD, 8'd77, 1, 0, 32'hFFFF_FFFF);
    chk("R3 global pa", physAddr, 32'h1234_ABCD);

    // R6 R7: domain 2 field at bits 5:4, entry perm 10 (user ok, no write)
    doLookup("R7", 32'h4000_0010, 8'd9, 0, 1, 32'h0000_0010);
    chk("R7 user write", 32'(permFault), 32'd1);
    doLookup("R7", 32'h4000_0010, 8'd9, 0, 0, 32'h0000_0010);
    chk("R7 user read", 32'(permFault), 32'd0);
    doLookup("R6", 32'h4000_0010, 8'd9, 0, 1, 32'h0000_0030);
    chk("R6 manager", 32'(permFault | domainFault), 32'd0);
    doLookup("R6", 32'h4000_0010, 8'd9, 1, 0, 32'h0000_0020);
    chk("R6 reserved", 32'(domainFault), 32'd1);

    // R10: identifier 1 cleared, global survives
    doInv(1, 8'd1, 20'h0);
    doLookup("R10", 32'h0012_3456, 8'd1, 1, 0, 32'hFFFF_FFFF);
    chk("R10 cleared", 32'(hit), 32'd0);
    doLookup("R10", 32'h4000_0000, 8'd9, 1, 0, 32'hFFFF_FFFF);
    chk("R10 global kept", 32'(hit), 32'd1);

    // R11: address inside 64KB global page clears it
    doInv(2, 8'd0, 20'h4000F);
    doLookup("R11", 32'h4000_0000, 8'd9, 1, 0, 32'hFFFF_FFFF);
    chk("R11 cleared", 32'(hit), 32'd0);

    // R9: invAll
    doRefill(20'h00200, 20'h00300, 2'b00, 8'd4, 0, 4'd0, 2'b11, 5'h1, 0);
    doInv(0, 8'd0, 20'h0);
    doLookup("R9", 32'h0020_0000, 8'd4, 1, 0, 32'hFFFF_FFFF);
    chk("R9 cleared", 32'(hit), 32'd0);

    // R5: 33 refills, the last overwrites the slot of the first
    for (int k = 0; k < N + 1; k++)
      doRefill(20'h10000 + 20'(k), 20'h20000 + 20'(k), 2'b00, 8'd3, 0,
               4'd0, 2'b11, 5'(k), 0);
    doLookup("R5", 32'h1000_0000, 8'd3, 1, 0, 32'hFFFF_FFFF);
    chk("R5 oldest evicted", 32'(hit), 32'd0);
    doLookup("R5", 32'h1002_0004, 8'd3, 1, 0, 32'hFFFF_FFFF);
    chk("R5 newest pa", physAddr, 32'h2002_0004);
    doLookup("R5", 32'h1000_1000, 8'd3, 1, 0, 32'hFFFF_FFFF);
    chk("R5 second kept", 32'(hit), 32'd1);

    // R12: refill together with invAll keeps the new entry only
    doRefill(20'h55500, 20'h66600, 2'b10, 8'd5, 0, 4'd0, 2'b11, 5'h7, 1);
    doLookup("R12", 32'h5551_2345, 8'd5, 1, 0, 32'hFFFF_FFFF);
    chk("R12 new pa", physAddr, 32'h6661_2345);
    doLookup("R12", 32'h1000_1000, 8'd3, 1, 0, 32'hFFFF_FFFF);
    chk("R12 others gone", 32'(hit), 32'd0);

    // random mix
    for (int it = 0; it < 3000; it++) begin
      int op = $urandom % 100;
      logic [31:0] r = $urandom;
      logic [19:0] vp = r[19:0] & 20'h0331F;
      if (op < 25)
        doRefill(vp, 20'($urandom), 2'($urandom), 8'($urandom % 4),
                 ($urandom % 4) == 0, 4'($urandom), 2'($urandom),
                 5'($urandom), ($urandom % 64) == 0);
      else if (op < 27) doInv(0, 8'd0, 20'h0);
      else if (op < 32) doInv(1, 8'($urandom % 4), 20'h0);
      else if (op < 37) doInv(2, 8'd0, vp);
      else if (op < 40) begin
        @(negedge clk); clearIns(); #1;
        chk("R13 idle", 32'({hit, missReq}), 32'd0);
      end else
        doLookup("R2 R3 R4", {vp, 12'($urandom)}, 8'($urandom % 4),
                 1'($urandom), 1'($urandom), $urandom);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule